// File: doc/BRIEF.md
# Framed Test-Pattern Generator

This block produces a serial test stream arranged as frames. A frame is made of lines. Each line opens with a programmable number of overhead bytes, taken from an external byte-wide word memory, and the rest of the line is payload. The source of the payload depends on a mode input:

- word data from the same memory;
- a 2^7−1 pseudo-random sequence;
- a run of identical bits of programmable length, followed by the pseudo-random sequence.

The block sends one bit per clock, most significant bit first. Flags mark the bit types, so a matching checker downstream can separate overhead errors from payload errors:

- overhead bit;
- payload bit;
- first bit of a line;
- first bit of a frame;
- which of two stored patterns is active.

A sequence is a programmable number of frames. At the end of a sequence the memory walk starts again from the beginning. In alternate mode a level input picks pattern A or pattern B, which sit in two halves of the memory. The choice is taken only at a frame boundary.

The memory read port is asynchronous: `mem_data` must show the byte at `mem_addr` in the same cycle. The geometry inputs are held steady while `run` is high. Range limits on the geometry are left to the caller.

Top module: `fpg_frame_gen`

## Requirements
- R1: While `rst_n` is low or `run` is low, `ser_out` and every flag output are 0. Dropping `run` restarts the stream at frame 0, line 0, byte 0, bit 0.
- R2: A line is `line_bytes` bytes, a frame is `lines_per_frame` lines, and a sequence is `frame_count` frames. `line_flag` is 1 on the first bit of every line. `frame_flag` is 1 on the first bit of every frame.
- R3: One bit is sent per clock, and bit 7 of each byte goes first.
- R4: The first `oh_bytes` bytes of each line are overhead, with `ovh_flag`=1, and are read from memory. The remaining bytes are payload, with `pay_flag`=1. While running, exactly one of the two flags is 1.
- R5: `mem_addr` = {bank bit, pointer}. The pointer starts at 0 and steps by one after each byte sourced from memory. It returns to 0 after the last bit of the sequence.
- R6: When `pl_mode` = 0 (word mode), payload bytes also come from memory through the same pointer.
- R7: When `pl_mode` = 1 or 3, each payload bit is the pseudo-random output. The 7-bit register s is set to all ones while `run` is low. The output bit is s[6], and the next state is {s[5:0], s[6]^s[5]}. The register steps only on bits it supplies.
- R8: When `pl_mode` = 2, the first `cid_bits` payload bits of each line equal `cid_value`. The rest of that line's payload comes from the sequence of R7. A length of 0 gives pure pseudo-random payload.
- R9: With `alt_en`=1, a high `alt_sel` selects pattern A (bank bit 0) and a low `alt_sel` selects pattern B (bank bit 1). The level is sampled while idle and on the last bit of each frame. `pat_b` shows the bank and changes only at a frame start.
- R10: With `alt_en`=0, the bank bit and `pat_b` stay 0 whatever `alt_sel` does.
- R11: After the last bit of a sequence, the next bit starts a new sequence. The pseudo-random register is not reseeded at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Stream enable; low holds the start state |
| pl_mode | input | 2 | Payload source: 0 word, 1 random, 2 run+random, 3 random |
| line_bytes | input | 16 | Bytes per line |
| oh_bytes | input | 16 | Overhead bytes per line |
| lines_per_frame | input | 5 | Lines per frame (1 to 16) |
| frame_count | input | 14 | Frames per sequence |
| cid_bits | input | 18 | Length of the identical-bit run per line |
| cid_value | input | 1 | Value of the identical-bit run |
| alt_en | input | 1 | Enables A/B pattern selection |
| alt_sel | input | 1 | High selects A, low selects B |
| mem_addr | output | 13 | Word-memory address {bank, pointer} |
| mem_data | input | 8 | Word-memory byte at `mem_addr` |
| ser_out | output | 1 | Serial stream |
| ovh_flag | output | 1 | Current bit is overhead |
| pay_flag | output | 1 | Current bit is payload |
| line_flag | output | 1 | First bit of a line |
| frame_flag | output | 1 | First bit of a frame |
| pat_b | output | 1 | Pattern B is active |

## Verification
On every cycle the assertions check four things: exactly one of overhead and payload is flagged, a new line follows each line end, a line with overhead opens in overhead, and `pat_b` moves only on a frame start. They also keep the random register away from the all-zero lock-up state. Only the bench scenarios can show that the bit values are right in each mode. That covers the MSB-first order, the memory pointer walk and its restart at the end of a sequence, and the run length and polarity in the identical-bit mode. The bench also shows that a change of `alt_sel` in mid-frame is held back until the next frame.

// File: rtl/fpg_pkg.sv
// Shared types for the framed test-pattern generator.
package fpg_pkg;
    // Payload source selection; code 3 behaves like PL_PRBS.
    typedef enum logic [1:0] {
        PL_WORD = 2'd0,
        PL_PRBS = 2'd1,
        PL_CID  = 2'd2,
        PL_RSVD = 2'd3
    } pl_mode_e;
endpackage

// File: rtl/fpg_geom_ctr.sv
// Frame geometry counters: bit, byte, line and frame position.
// Assumes the geometry inputs are steady while run is high and that
// line_bytes, lines and frames are non-zero. Holds at zero while idle.
module fpg_geom_ctr #(
    parameter int LB_W = 16,
    parameter int LN_W = 5,
    parameter int FR_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [LB_W-1:0] line_bytes,
    input  logic [LB_W-1:0] oh_bytes,
    input  logic [LN_W-1:0] lines,
    input  logic [FR_W-1:0] frames,
    output logic [2:0]      bit_idx,
    output logic            in_oh,
    output logic            line_first,
    output logic            frame_first,
    output logic            byte_last,
    output logic            line_last,
    output logic            frame_last,
    output logic            seq_last
);
    localparam logic [LB_W-1:0] LB_ONE = LB_W'(1);
    localparam logic [LN_W-1:0] LN_ONE = LN_W'(1);
    localparam logic [FR_W-1:0] FR_ONE = FR_W'(1);

    logic [2:0]      bit_q;
    logic [LB_W-1:0] byte_q;
    logic [LN_W-1:0] line_q;
    logic [FR_W-1:0] frame_q;

    // Position decode: the end of each level and the start markers.
    always_comb begin
        bit_idx     = bit_q;
        in_oh       = byte_q < oh_bytes;
        byte_last   = bit_q == 3'd7;
        line_last   = byte_last && (byte_q == line_bytes - LB_ONE);
        frame_last  = line_last && (line_q == lines - LN_ONE);
        seq_last    = frame_last && (frame_q == frames - FR_ONE);
        line_first  = (bit_q == 3'd0) && (byte_q == '0);
        frame_first = line_first && (line_q == '0);
    end

    // Advance the nested counters by one bit each running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            bit_q   <= '0;
            byte_q  <= '0;
            line_q  <= '0;
            frame_q <= '0;
        end else begin
            bit_q <= bit_q + 3'd1;
            if (byte_last) begin
                if (line_last) begin
                    byte_q <= '0;
                    if (frame_last) begin
                        line_q  <= '0;
                        frame_q <= seq_last ? '0 : frame_q + FR_ONE;
                    end else begin
                        line_q <= line_q + LN_ONE;
                    end
                end else begin
                    byte_q <= byte_q + LB_ONE;
                end
            end
        end
    end

    // R2: a line end is followed by a line start.
    a_r2_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
        run && line_last |=> !run || line_first);

    // R4: a line with overhead opens in overhead.
    a_r4_oh_leads: assert property (@(posedge clk) disable iff (!rst_n)
        run && line_first && (oh_bytes != '0) |-> in_oh);
endmodule

// File: rtl/fpg_prbs7.sv
// 2^7-1 pseudo-random source, polynomial x^7+x^6+1.
// Reseeds to all ones while reseed is high and steps when step is high.
// The output is the oldest stage.
module fpg_prbs7 (
    input  logic clk,
    input  logic rst_n,
    input  logic reseed,
    input  logic step,
    output logic bit_out
);
    logic [6:0] s_q;

    // Shift register with the feedback tap at stages 7 and 6.
    always_ff @(posedge clk) begin
        if (!rst_n || reseed) begin
            s_q <= 7'h7F;
        end else if (step) begin
            s_q <= {s_q[5:0], s_q[6] ^ s_q[5]};
        end
    end

    assign bit_out = s_q[6];

    // R7: the register never reaches the all-zero lock-up state.
    a_r7_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> s_q != 7'h00);
endmodule

// File: rtl/fpg_frame_gen.sv
// Framed test-pattern generator top.
// Overhead comes from an external word memory. Payload comes from the
// memory, from a PRBS7, or from a run of identical bits followed by PRBS7.
// Assumes the memory read is combinational, so mem_data follows mem_addr
// within the same cycle.
module fpg_frame_gen
    import fpg_pkg::*;
#(
    parameter int LB_W   = 16,
    parameter int LN_W   = 5,
    parameter int FR_W   = 14,
    parameter int CID_W  = 18,
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [1:0]        pl_mode,
    input  logic [LB_W-1:0]   line_bytes,
    input  logic [LB_W-1:0]   oh_bytes,
    input  logic [LN_W-1:0]   lines_per_frame,
    input  logic [FR_W-1:0]   frame_count,
    input  logic [CID_W-1:0]  cid_bits,
    input  logic              cid_value,
    input  logic              alt_en,
    input  logic              alt_sel,
    output logic [MEM_AW:0]   mem_addr,
    input  logic [7:0]        mem_data,
    output logic              ser_out,
    output logic              ovh_flag,
    output logic              pay_flag,
    output logic              line_flag,
    output logic              frame_flag,
    output logic              pat_b
);
    localparam logic [MEM_AW-1:0] PTR_ONE = MEM_AW'(1);
    localparam logic [CID_W-1:0]  CID_ONE = CID_W'(1);

    pl_mode_e        mode;
    logic            go;
    logic [2:0]      bit_idx;
    logic            in_oh, line_first, frame_first;
    logic            byte_last, line_last, frame_last, seq_last;
    logic            from_mem, cid_phase, use_prbs, prbs_bit, raw_bit;
    logic [MEM_AW-1:0] ptr_q;
    logic            bank_q;
    logic [CID_W-1:0] pl_cnt_q;

    assign mode = pl_mode_e'(pl_mode);
    assign go   = run && rst_n;

    fpg_geom_ctr #(.LB_W(LB_W), .LN_W(LN_W), .FR_W(FR_W)) u_geom (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .line_bytes (line_bytes),
        .oh_bytes   (oh_bytes),
        .lines      (lines_per_frame),
        .frames     (frame_count),
        .bit_idx    (bit_idx),
        .in_oh      (in_oh),
        .line_first (line_first),
        .frame_first(frame_first),
        .byte_last  (byte_last),
        .line_last  (line_last),
        .frame_last (frame_last),
        .seq_last   (seq_last)
    );

    fpg_prbs7 u_prbs (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (!run),
        .step   (go && use_prbs),
        .bit_out(prbs_bit)
    );

    // Pick the source of the current bit.
    always_comb begin
        from_mem  = in_oh || (mode == PL_WORD);
        cid_phase = !in_oh && (mode == PL_CID) && (pl_cnt_q < cid_bits);
        use_prbs  = !from_mem && !cid_phase;
        if (from_mem)       raw_bit = mem_data[3'd7 - bit_idx];
        else if (cid_phase) raw_bit = cid_value;
        else                raw_bit = prbs_bit;
    end

    // Memory pointer: one step per memory byte, cleared at sequence end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)                ptr_q <= '0;
        else if (seq_last)                 ptr_q <= '0;
        else if (byte_last && from_mem)    ptr_q <= ptr_q + PTR_ONE;
    end

    // Pattern bank: sampled while idle and on the last bit of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                        bank_q <= 1'b0;
        else if (!run || frame_last)       bank_q <= alt_en && !alt_sel;
    end

    // Payload bit index within the line, used for the identical-bit run.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || line_last)   pl_cnt_q <= '0;
        else if (!in_oh && pl_cnt_q != '1) pl_cnt_q <= pl_cnt_q + CID_ONE;
    end

    // Output drive, forced low while idle or in reset.
    always_comb begin
        mem_addr   = {bank_q, ptr_q};
        ser_out    = go && raw_bit;
        ovh_flag   = go && in_oh;
        pay_flag   = go && !in_oh;
        line_flag  = go && line_first;
        frame_flag = go && frame_first;
        pat_b      = bank_q;
    end

    // R4: exactly one bit class is flagged while running.
    a_r4_one_class: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> $onehot({ovh_flag, pay_flag}));

    // R9: the pattern bank moves only on a frame start.
    a_r9_bank_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && !frame_flag |-> $stable(pat_b));
endmodule

// File: tb/fpg_frame_gen_test.sv
`timescale 1ns/1ps
module fpg_frame_gen_test;
    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] lb;
        logic [15:0] oh;
        logic [4:0]  ln;
        logic [13:0] fc;
        logic [17:0] cid;
        logic        cv;
        logic        ae;
        logic        as;
        logic [15:0] cyc;
    } cfg_t;

    // Stimulus table; the expected stream is computed by the model below.
    localparam cfg_t CFG [7] = '{
        '{2'd0, 16'd6, 16'd2, 5'd2,  14'd3, 18'd0,  1'b0, 1'b0, 1'b0, 16'd400}, // R3 R4 R5 R6 R10 R11
        '{2'd1, 16'd8, 16'd4, 5'd3,  14'd2, 18'd0,  1'b0, 1'b0, 1'b1, 16'd500}, // R7 R11
        '{2'd2, 16'd6, 16'd2, 5'd2,  14'd2, 18'd5,  1'b1, 1'b0, 1'b0, 16'd300}, // R8
        '{2'd2, 16'd5, 16'd1, 5'd1,  14'd4, 18'd0,  1'b1, 1'b0, 1'b0, 16'd200}, // R8 zero run
        '{2'd2, 16'd6, 16'd2, 5'd1,  14'd2, 18'd32, 1'b0, 1'b0, 1'b0, 16'd200}, // R8 full run
        '{2'd0, 16'd6, 16'd2, 5'd1,  14'd2, 18'd0,  1'b0, 1'b1, 1'b0, 16'd200}, // R9 B
        '{2'd3, 16'd4, 16'd1, 5'd16, 14'd1, 18'd0,  1'b0, 1'b0, 1'b0, 16'd600}  // R2 R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  pl_mode = '0;
    logic [15:0] line_bytes = 16'd6;
    logic [15:0] oh_bytes = 16'd2;
    logic [4:0]  lines_per_frame = 5'd1;
    logic [13:0] frame_count = 14'd1;
    logic [17:0] cid_bits = '0;
    logic        cid_value = 1'b0;
    logic        alt_en = 1'b0;
    logic        alt_sel = 1'b0;
    logic [12:0] mem_addr;
    logic [7:0]  mem_data;
    logic        ser_out, ovh_flag, pay_flag, line_flag, frame_flag, pat_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [12:0] a);
        return a[7:0] ^ (a[12] ? 8'hA5 : 8'h3C);
    endfunction

    assign mem_data = memf(mem_addr);

    fpg_frame_gen uut (
        .clk(clk), .rst_n(rst_n), .run(run), .pl_mode(pl_mode),
        .line_bytes(line_bytes), .oh_bytes(oh_bytes),
        .lines_per_frame(lines_per_frame), .frame_count(frame_count),
        .cid_bits(cid_bits), .cid_value(cid_value),
        .alt_en(alt_en), .alt_sel(alt_sel), .mem_addr(mem_addr),
        .mem_data(mem_data), .ser_out(ser_out), .ovh_flag(ovh_flag),
        .pay_flag(pay_flag), .line_flag(line_flag),
        .frame_flag(frame_flag), .pat_b(pat_b)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Applies one configuration and compares every cycle with the model.
    task automatic run_cfg(input cfg_t c, input string tag, input int sw_at);
        logic [15:0] m_byte;
        logic [4:0]  m_line;
        logic [13:0] m_frame;
        logic [2:0]  m_bit;
        logic [11:0] m_ptr;
        logic        m_bank;
        logic [17:0] m_pl;
        logic [6:0]  m_s;
        logic        m_oh, m_mem, m_cidp, m_out;
        logic [18:0] expv;
        pl_mode    = c.mode;
        line_bytes = c.lb;
        oh_bytes   = c.oh;
        lines_per_frame = c.ln;
        frame_count = c.fc;
        cid_bits   = c.cid;
        cid_value  = c.cv;
        alt_en     = c.ae;
        alt_sel    = c.as;
        run        = 1'b0;
        @(negedge clk);
        @(negedge clk);
        run = 1'b1;
        m_byte = '0; m_line = '0; m_frame = '0; m_bit = '0; m_ptr = '0;
        m_pl = '0; m_s = 7'h7F; m_bank = c.ae && !c.as;
        for (int i = 0; i < int'(c.cyc); i++) begin
            #1;
            m_oh   = m_byte < c.oh;
            m_mem  = m_oh || (c.mode == 2'd0);
            m_cidp = !m_oh && (c.mode == 2'd2) && (m_pl < c.cid);
            if (m_mem)       m_out = memf({m_bank, m_ptr})[3'd7 - m_bit];
            else if (m_cidp) m_out = c.cv;
            else             m_out = m_s[6];
            expv = {m_out, m_oh, !m_oh, (m_bit == 0 && m_byte == 0),
                    (m_bit == 0 && m_byte == 0 && m_line == 0), m_bank,
                    m_bank, m_ptr};
            check(tag, 32'({ser_out, ovh_flag, pay_flag, line_flag,
                            frame_flag, pat_b, mem_addr}), 32'(expv));
            if (i == sw_at) alt_sel = ~alt_sel;
            // Advance the model by one bit.
            if (!m_mem && !m_cidp) m_s = {m_s[5:0], m_s[6] ^ m_s[5]};
            if (!m_oh) m_pl = m_pl + 1;
            if (m_bit == 3'd7) begin
                if (m_mem) m_ptr = m_ptr + 1;
                if (m_byte == c.lb - 1) begin
                    m_byte = '0;
                    m_pl = '0;
                    if (m_line == c.ln - 1) begin
                        m_line = '0;
                        m_bank = c.ae && !alt_sel;
                        if (m_frame == c.fc - 1) begin
                            m_frame = '0;
                            m_ptr = '0;
                        end else m_frame = m_frame + 1;
                    end else m_line = m_line + 1;
                end else m_byte = m_byte + 1;
            end
            m_bit = m_bit + 3'd1;
            @(negedge clk);
        end
        run = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs stay low while reset is held, even with run high.
        run = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset", 32'({ser_out, ovh_flag, pay_flag, line_flag, frame_flag}), 32'd0);
        run = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R1 idle", 32'({ser_out, ovh_flag, pay_flag, line_flag, frame_flag, pat_b}), 32'd0);
        @(negedge clk);

        // Table walk: the whole stream, flags and addresses in each mode.
        for (int k = 0; k < 7; k++) begin
            string tag;
            case (k)
                0: tag = "R3 R4 R5 R6 R10 R11 word";
                1: tag = "R7 R11 random";
                2: tag = "R8 run";
                3: tag = "R8 zero run";
                4: tag = "R8 full run";
                5: tag = "R9 pattern B";
                default: tag = "R2 sixteen lines";
            endcase
            run_cfg(CFG[k], tag, -1);
        end

        // R10: alt_sel is ignored while alternate mode is off.
        alt_en = 1'b0;
        alt_sel = 1'b0;
        @(negedge clk);
        #1;
        check("R10 bank off", 32'({pat_b, mem_addr[12]}), 32'd0);
        @(negedge clk);

        // R9: a mid-frame switch from A to B waits for the frame start (96 bits).
        run_cfg('{2'd0, 16'd6, 16'd2, 5'd2, 14'd2, 18'd0, 1'b0, 1'b1, 1'b1, 16'd220},
                "R9 switch", 30);
        check("R9 end on B", 32'(pat_b), 32'd1);

        // R1: dropping run mid-line restarts at the frame start.
        run_cfg('{2'd1, 16'd6, 16'd2, 5'd2, 14'd2, 18'd0, 1'b0, 1'b0, 1'b0, 16'd37},
                "R1 restart a", -1);
        run_cfg('{2'd1, 16'd6, 16'd2, 5'd2, 14'd2, 18'd0, 1'b0, 1'b0, 1'b0, 16'd60},
                "R1 restart b", -1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule